// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is a bank of up to 32 general-purpose lines, grouped as four 8-bit ports A to D and controlled through a small 32-bit register bus. Software chooses a function select bit, a direction and an output value for every line. It reads back the line levels, which pass through a two-stage synchroniser. It programs a 2-bit edge mode per line. A mode of zero turns the line's interrupt off, and the other codes pick falling, rising or both edges.

Qualifying edges set sticky status bits, and software clears them by writing ones. Each CPU has a routing mask register that selects which status bits reach it. Each CPU gets a level-high, registered interrupt output. A build-time parameter chooses between two ways of packing the ports into the 32-bit words, so the bank can match software written for either layout.

Register map (byte offsets):

| Offset | Register |
|---|---|
| 0x00 | function select |
| 0x08 | direction |
| 0x0C | data |
| 0x10 | status |
| 0x14 | low mode word |
| 0x18 | high mode word |
| 0x40 + 4*c | routing mask of CPU c |

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every line is an input (pin_oe all zero) and irq_o is all zero. The function select, direction, data output, status and both mode words read 0. Every routing mask reads with all implemented line bits set.
- R2: Direction bit 1 makes a line an output and bit 0 makes it an input. A data write drives pin_o. A data read returns the output latch for output lines and the synchronised pin level for input lines.
- R3: Edge-mode codes are 0 = off, 1 = falling, 2 = rising, 3 = both. A status bit is set only by an edge on its line in a direction that the line's mode enables.
- R4: Writing the status register clears each bit written as 1 and leaves every bit written as 0 unchanged. Status bits never clear without such a write.
- R5: If a qualifying edge and a clearing write hit the same status bit in the same cycle, the bit ends set.
- R6: irq_o[c] is a registered, level-high OR of (status AND routing mask of CPU c). It stays high until software clears the bits.
- R7: A line's status reaches CPU c only when bit c's mask has that line's bit set. A routing mask reads back what was written to it.
- R8: Port packing depends on SWAP_PORTS. With SWAP_PORTS=0, line n uses bit n of the 1-bit registers and mode bits 2n..2n+1 counted across the two mode words, where bit 32 and above fall into the high word. With SWAP_PORTS=1, pin k of port p (line 8p+k) uses bit 8*(3-p)+k, and its mode field starts at 2*(8*(p XOR 1)+k).
- R9: Register bits that map to no implemented line (line index >= NUM_LINES) read 0, and writes to them have no effect.
- R10: The function select register stores written values per line, drives pin_func and reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_addr | input | ADDR_W | byte address of the register |
| bus_we | input | 1 | write strobe |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, registered one cycle after the address |
| pin_i | input | NUM_LINES | asynchronous pin levels |
| pin_o | output | NUM_LINES | output latch |
| pin_oe | output | NUM_LINES | output enable (direction) |
| pin_func | output | NUM_LINES | function select per line |
| irq_o | output | NUM_CPUS | interrupt per CPU |

## Verification
The edge logic is tested with three line-level patterns. A rise across lines set to rising, falling, both and off shows which codes respond to a low-to-high transition, and the matching fall shows the opposite direction. A clear written in the same cycle as a fresh edge separates "edge wins" from "clear wins". A routing mask that admits a single line separates per-CPU gating from a shared OR. A second instance uses swapped packing and 20 lines, which shows whether bit and field positions, and the zeroed unimplemented bits, follow the selected layout.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned OFF_FUNC    = 32'h00;
  localparam int unsigned OFF_DIR     = 32'h08;
  localparam int unsigned OFF_DATA    = 32'h0C;
  localparam int unsigned OFF_STATUS  = 32'h10;
  localparam int unsigned OFF_MODE_LO = 32'h14;
  localparam int unsigned OFF_MODE_HI = 32'h18;
  localparam int unsigned OFF_ROUTE   = 32'h40;
  localparam int unsigned ROUTE_STEP  = 4;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  // position of a line inside the 1-bit-per-line words
  function automatic logic [4:0] bit_slot(input int line, input bit swap);
    int port;
    int pin;
    port = line / 8;
    pin  = line % 8;
    if (swap) return 5'(8 * (3 - port) + pin);
    return 5'(line);
  endfunction

  // first bit of a line's mode field across the two mode words
  function automatic logic [5:0] mode_slot(input int line, input bit swap);
    int port;
    int pin;
    port = line / 8;
    pin  = line % 8;
    if (swap) return 6'(2 * (8 * (port ^ 1) + pin));
    return 6'(2 * line);
  endfunction

endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  logic [N-1:0] meta_q;
  logic [N-1:0] sync_q;
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level_o = sync_q;
  assign rise_o  = sync_q & ~prev_q;
  assign fall_o  = ~sync_q & prev_q;

endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int unsigned N = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      rise_i,
  input  logic [N-1:0]      fall_i,
  input  logic [N-1:0][1:0] mode_i,
  input  logic [N-1:0]      clr_i,
  output logic [N-1:0]      status_o
);

  logic [N-1:0] hit;

  for (genvar l = 0; l < N; l++) begin : g_line
    assign hit[l] = (rise_i[l] & mode_i[l][1]) | (fall_i[l] & mode_i[l][0]);
  end

  // a fresh edge outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) status_o <= '0;
    else     status_o <= (status_o & ~clr_i) | hit;
  end

endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
  parameter int unsigned N    = 32,
  parameter int unsigned CPUS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N-1:0]            status_i,
  input  logic [CPUS-1:0][N-1:0]  mask_i,
  output logic [CPUS-1:0]         irq_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= '0;
    end else begin
      for (int c = 0; c < CPUS; c++) irq_o[c] <= |(status_i & mask_i[c]);
    end
  end

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned NUM_CPUS   = 2,
  parameter bit          SWAP_PORTS = 1'b0,
  parameter int unsigned ADDR_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] pin_i,
  output logic [NUM_LINES-1:0] pin_o,
  output logic [NUM_LINES-1:0] pin_oe,
  output logic [NUM_LINES-1:0] pin_func,
  output logic [NUM_CPUS-1:0]  irq_o
);

  localparam logic [ADDR_W-1:0] A_FUNC    = ADDR_W'(OFF_FUNC);
  localparam logic [ADDR_W-1:0] A_DIR     = ADDR_W'(OFF_DIR);
  localparam logic [ADDR_W-1:0] A_DATA    = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_MODE_LO = ADDR_W'(OFF_MODE_LO);
  localparam logic [ADDR_W-1:0] A_MODE_HI = ADDR_W'(OFF_MODE_HI);

  logic [NUM_LINES-1:0]                func_q, dir_q, out_q;
  logic [NUM_LINES-1:0][1:0]           mode_q;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0]  cpu_mask_q;
  logic [NUM_LINES-1:0]                level, rise, fall, status_q, clr;
  logic [NUM_LINES-1:0]                wr_line, mode_we, data_line;
  logic [NUM_LINES-1:0][1:0]           wr_mode;
  logic                                hit_mode_lo, hit_mode_hi;
  logic [63:0]                         mode_flat;
  logic [31:0]                         rd_next;

  function automatic logic [31:0] pack_line(input logic [NUM_LINES-1:0] v);
    logic [31:0] w;
    w = '0;
    for (int l = 0; l < NUM_LINES; l++) w[bit_slot(l, SWAP_PORTS)] = v[l];
    return w;
  endfunction

  assign hit_mode_lo = bus_we && (bus_addr == A_MODE_LO);
  assign hit_mode_hi = bus_we && (bus_addr == A_MODE_HI);

  // unpack write data into line order
  always_comb begin
    wr_line = '0;
    wr_mode = '0;
    mode_we = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      logic [5:0] ms;
      ms         = mode_slot(l, SWAP_PORTS);
      wr_line[l] = bus_wdata[bit_slot(l, SWAP_PORTS)];
      wr_mode[l] = bus_wdata[ms[4:0] +: 2];
      mode_we[l] = ms[5] ? hit_mode_hi : hit_mode_lo;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      func_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      mode_q <= '0;
    end else begin
      if (bus_we && bus_addr == A_FUNC) func_q <= wr_line;
      if (bus_we && bus_addr == A_DIR)  dir_q  <= wr_line;
      if (bus_we && bus_addr == A_DATA) out_q  <= wr_line;
      for (int l = 0; l < NUM_LINES; l++)
        if (mode_we[l]) mode_q[l] <= wr_mode[l];
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_route
    localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(OFF_ROUTE + ROUTE_STEP * c);
    always_ff @(posedge clk) begin
      if (rst)                                cpu_mask_q[c] <= '1;
      else if (bus_we && bus_addr == A_ROUTE) cpu_mask_q[c] <= wr_line;
    end
  end

  assign clr = (bus_we && bus_addr == A_STATUS) ? wr_line : '0;

  gpio_sync_edge #(.N(NUM_LINES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_i   (pin_i),
    .level_o (level),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  gpio_edge_status #(.N(NUM_LINES)) u_status (
    .clk      (clk),
    .rst      (rst),
    .rise_i   (rise),
    .fall_i   (fall),
    .mode_i   (mode_q),
    .clr_i    (clr),
    .status_o (status_q)
  );

  gpio_irq_route #(.N(NUM_LINES), .CPUS(NUM_CPUS)) u_route (
    .clk      (clk),
    .rst      (rst),
    .status_i (status_q),
    .mask_i   (cpu_mask_q),
    .irq_o    (irq_o)
  );

  assign data_line = (dir_q & out_q) | (~dir_q & level);

  always_comb begin
    mode_flat = '0;
    for (int l = 0; l < NUM_LINES; l++)
      mode_flat[mode_slot(l, SWAP_PORTS) +: 2] = mode_q[l];
  end

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      A_FUNC:    rd_next = pack_line(func_q);
      A_DIR:     rd_next = pack_line(dir_q);
      A_DATA:    rd_next = pack_line(data_line);
      A_STATUS:  rd_next = pack_line(status_q);
      A_MODE_LO: rd_next = mode_flat[31:0];
      A_MODE_HI: rd_next = mode_flat[63:32];
      default: begin
        for (int c = 0; c < NUM_CPUS; c++)
          if (bus_addr == ADDR_W'(OFF_ROUTE + ROUTE_STEP * c))
            rd_next = pack_line(cpu_mask_q[c]);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  assign pin_o    = out_q;
  assign pin_oe   = dir_q;
  assign pin_func = func_q;

endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned NUM_CPUS  = 2,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                                clk,
  input logic                                rst,
  input logic                                bus_we,
  input logic [ADDR_W-1:0]                   bus_addr,
  input logic [NUM_LINES-1:0]                status_q,
  input logic [NUM_LINES-1:0]                rise,
  input logic [NUM_LINES-1:0]                fall,
  input logic [NUM_LINES-1:0][1:0]           mode_q,
  input logic [NUM_CPUS-1:0][NUM_LINES-1:0]  cpu_mask_q,
  input logic [NUM_CPUS-1:0]                 irq_o
);

  logic [NUM_LINES-1:0] armed;
  logic                 clr_wr;

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++)
      armed[l] = (rise[l] && mode_q[l] inside {EDGE_RISE, EDGE_BOTH}) ||
                 (fall[l] && mode_q[l] inside {EDGE_FALL, EDGE_BOTH});
  end

  assign clr_wr = bus_we && (bus_addr == ADDR_W'(OFF_STATUS));

  AST_NO_UNARMED_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(armed)) == '0)); // R3

  AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> ((status_q & $past(status_q)) == $past(status_q))); // R4

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (armed != '0) |=> ((status_q & $past(armed)) == $past(armed))); // R5

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
      ((status_q & cpu_mask_q[c]) != '0) |=> irq_o[c]); // R6

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
      ((status_q & cpu_mask_q[c]) == '0) |=> !irq_o[c]); // R7
  end

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(
  .NUM_LINES (NUM_LINES),
  .NUM_CPUS  (NUM_CPUS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .status_q   (status_q),
  .rise       (rise),
  .fall       (fall),
  .mode_q     (mode_q),
  .cpu_mask_q (cpu_mask_q),
  .irq_o      (irq_o)
);

// File: tb/gpio_edge_bank_bench.sv
module gpio_edge_bank_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        we_a = 1'b0, we_b = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic [31:0] pins_a = '0;
  logic [19:0] pins_b = '0;
  logic [31:0] pout_a, poe_a, pfunc_a;
  logic [19:0] pout_b, poe_b, pfunc_b;
  logic [1:0]  irq_a;
  logic [0:0]  irq_b;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  gpio_edge_bank #(.NUM_LINES(32), .NUM_CPUS(2), .SWAP_PORTS(1'b0), .ADDR_W(8)) u_gpio_edge_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(we_a), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_a), .pin_i(pins_a), .pin_o(pout_a), .pin_oe(poe_a),
    .pin_func(pfunc_a), .irq_o(irq_a));

  gpio_edge_bank #(.NUM_LINES(20), .NUM_CPUS(1), .SWAP_PORTS(1'b1), .ADDR_W(8)) u_gpio_edge_bank_sw (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(we_b), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_b), .pin_i(pins_b), .pin_o(pout_b), .pin_oe(poe_b),
    .pin_func(pfunc_b), .irq_o(irq_b));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit sw, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d;
    if (sw) we_b = 1'b1; else we_a = 1'b1;
    @(negedge clk);
    we_a = 1'b0; we_b = 1'b0;
  endtask

  task automatic rd(input bit sw, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = sw ? rdata_b : rdata_a;
  endtask

  task automatic set_pins_a(input logic [31:0] v);
    @(negedge clk);
    pins_a = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_pins_b(input logic [19:0] v);
    @(negedge clk);
    pins_b = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(0, 8'h00, rv); check("R1 func", rv, 32'h0);
    rd(0, 8'h08, rv); check("R1 dir", rv, 32'h0);
    rd(0, 8'h0C, rv); check("R1 data", rv, 32'h0);
    rd(0, 8'h10, rv); check("R1 status", rv, 32'h0);
    rd(0, 8'h14, rv); check("R1 mode lo", rv, 32'h0);
    rd(0, 8'h18, rv); check("R1 mode hi", rv, 32'h0);
    rd(0, 8'h40, rv); check("R1 route0", rv, 32'hFFFF_FFFF);
    rd(0, 8'h44, rv); check("R1 route1", rv, 32'hFFFF_FFFF);
    rd(1, 8'h40, rv); check("R1 R9 swapped route0", rv, 32'hFFFF_0F00);
    check("R1 pin_oe", poe_a, 32'h0);
    check("R1 irq", {30'd0, irq_a}, 32'h0);
  endtask

  task automatic t_func;
    wr(0, 8'h00, 32'hA5A5_0F0F);
    rd(0, 8'h00, rv); check("R10 readback", rv, 32'hA5A5_0F0F);
    check("R10 pin_func", pfunc_a, 32'hA5A5_0F0F);
  endtask

  task automatic t_dir_data;
    wr(0, 8'h08, 32'h0000_FFFF);
    wr(0, 8'h0C, 32'h1234_5678);
    check("R2 pin_oe", poe_a, 32'h0000_FFFF);
    check("R2 pin_o", pout_a, 32'h1234_5678);
    set_pins_a(32'hABCD_0000);
    rd(0, 8'h0C, rv); check("R2 data mix", rv, 32'hABCD_5678);
    set_pins_a(32'h0);
    rd(0, 8'h10, rv); check("R3 mode off no status", rv, 32'h0);
  endtask

  task automatic t_modes;
    // line8 rise, line9 fall, line10 both, line11 off, line20 both
    wr(0, 8'h14, 32'h0036_0000);
    wr(0, 8'h18, 32'h0000_0300);
    rd(0, 8'h14, rv); check("R8 mode lo layout", rv, 32'h0036_0000);
    rd(0, 8'h18, rv); check("R8 mode hi layout", rv, 32'h0000_0300);
    set_pins_a(32'h0010_0F00);
    rd(0, 8'h10, rv); check("R3 rising edges", rv, 32'h0010_0500);
    check("R6 irq high", {30'd0, irq_a}, 32'h3);
    wr(0, 8'h10, 32'h0);
    rd(0, 8'h10, rv); check("R4 zero write", rv, 32'h0010_0500);
    wr(0, 8'h10, 32'h0000_0100);
    rd(0, 8'h10, rv); check("R4 single clear", rv, 32'h0010_0400);
    check("R6 irq still high", {30'd0, irq_a}, 32'h3);
    set_pins_a(32'h0);
    rd(0, 8'h10, rv); check("R3 falling edges", rv, 32'h0010_0600);
    wr(0, 8'h10, 32'hFFFF_FFFF);
    rd(0, 8'h10, rv); check("R4 clear all", rv, 32'h0);
    check("R6 irq low", {30'd0, irq_a}, 32'h0);
  endtask

  task automatic t_route;
    wr(0, 8'h44, 32'h0000_0400);
    rd(0, 8'h44, rv); check("R7 route readback", rv, 32'h0000_0400);
    set_pins_a(32'h0000_0100);
    check("R7 only cpu0", {30'd0, irq_a}, 32'h1);
    set_pins_a(32'h0000_0500);
    check("R7 both cpus", {30'd0, irq_a}, 32'h3);
    wr(0, 8'h10, 32'hFFFF_FFFF);
    wr(0, 8'h44, 32'hFFFF_FFFF);
    check("R6 cleared", {30'd0, irq_a}, 32'h0);
  endtask

  task automatic t_collision;
    set_pins_a(32'h0000_0100);   // line10 falls, both mode
    rd(0, 8'h10, rv); check("R3 fall on both", rv, 32'h0000_0400);
    @(negedge clk);
    pins_a = 32'h0000_0500;      // line10 rises again
    @(negedge clk);
    @(negedge clk);
    bus_addr = 8'h10; bus_wdata = 32'h0000_0400; we_a = 1'b1;
    @(negedge clk);
    we_a = 1'b0;
    rd(0, 8'h10, rv); check("R5 edge beats clear", rv, 32'h0000_0400);
    wr(0, 8'h10, 32'h0000_0400);
    rd(0, 8'h10, rv); check("R4 later clear", rv, 32'h0);
  endtask

  task automatic t_swapped;
    wr(1, 8'h08, 32'hFFFF_FFFF);
    rd(1, 8'h08, rv); check("R9 unused dir bits", rv, 32'hFFFF_0F00);
    check("R9 pin_oe", {12'd0, poe_b}, 32'h000F_FFFF);
    wr(1, 8'h08, 32'h0101_0000);
    check("R8 swapped dir", {12'd0, poe_b}, 32'h0000_0101);
    wr(1, 8'h14, 32'h0002_0000);  // line0 rise
    wr(1, 8'h18, 32'h0001_0000);  // line16 fall
    set_pins_b(20'h1_0001);
    rd(1, 8'h10, rv); check("R8 swapped rise", rv, 32'h0100_0000);
    check("R6 swapped irq", {31'd0, irq_b}, 32'h1);
    set_pins_b(20'h0_0001);
    rd(1, 8'h10, rv); check("R8 swapped fall", rv, 32'h0100_0100);
    wr(1, 8'h18, 32'hFFFF_FFFF);
    rd(1, 8'h18, rv); check("R9 unused mode bits", rv, 32'h00FF_0000);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_func();
    t_dir_data();
    t_modes();
    t_route();
    t_collision();
    t_swapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule